// File: doc/BRIEF.md
# Timed Load-Reservation Arbiter

This block sits between a small group of cores and the memory system and decides who holds a load-reserved / store-conditional reservation on each cache line. A core issues a reserve request for an address. If no other core owns that 64-byte line, the requester becomes its owner and a countdown of 64 instruction ticks starts. If another core already owns the line, the request does not disturb the existing reservation. The requester is stalled instead and waits in a queue ordered by core index.

The owner's countdown moves only on cycles where that core's tick input is high. The owner gives up the line when it issues any store-conditional, or when its countdown runs out (a lapse). Either event hands the line to the lowest-numbered waiting core on the same clock edge, and that core starts a fresh 64-tick countdown. Each store-conditional gets a one-cycle pass/fail reply. It passes only when the issuing core still owns the addressed line with a non-zero count.

Each core runs a three-state machine:
- `CS_IDLE`: holds nothing.
- `CS_WAIT`: stalled on a line.
- `CS_OWN`: holds the reservation.

The transitions are:
- `IDLE→OWN` and `WAIT→OWN`: win (free line, or the line was just released).
- `IDLE→WAIT`: lose (line owned, or a lower-indexed core won it).
- `OWN→IDLE`: release by store-conditional, or lapse when the last tick is consumed.
- `OWN→OWN`: keep, with the count stepping down on a tick, or a fresh count after re-reserving.
- `OWN→WAIT`: the owner re-reserves a line held by someone else.

Top module: `resv_arbiter`

## Requirements
- R1: A reserve request (`req_op` = 0) to a line nobody owns makes the core owner. `granted` pulses high for exactly one cycle, in the cycle after the request, and `stall` stays low.
- R2: A reserve request to a line owned by another core raises `stall` for the requester from the next cycle. The owner's reservation is untouched, and its later store-conditional still passes.
- R3: A new reservation starts with a count of 64. The count decreases by one only on cycles where the owner's `tick` is high; cycles without a tick leave it, and any waiter's stall, unchanged.
- R4: A store-conditional (`req_op` = 1) from the owner of the addressed line passes while the count is non-zero. The count is judged before any tick in the same cycle, so a store-conditional after 63 ticks passes even with `tick` high.
- R5: When the owner's 64th tick is consumed without a store-conditional, the reservation lapses. A later store-conditional from that core fails.
- R6: When an owner releases (store-conditional of any outcome, or lapse), a core waiting on that line gets `granted` and drops `stall` in the cycle after the release, with a fresh count of 64.
- R7: Several cores contending for one line, whether already waiting or requesting in the same cycle, are granted in ascending core index order.
- R8: A store-conditional from a core that owns no reservation on the addressed line fails. A core that issues one while waiting stays stalled.
- R9: Every store-conditional produces `sc_valid` high for exactly one cycle, in the cycle after the request. `sc_ok` is high only together with `sc_valid`.
- R10: Reset clears all reservations, stalls and replies. After reset, a reserve to a previously owned line is granted at once.
- R11: Addresses compare on line number (address bits above bit 5). At most one core owns a line, and cores owning different lines proceed independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NUM_CORES | Per-core request strobe |
| req_op | input | NUM_CORES | Per-core operation: 0 reserve, 1 store-conditional |
| req_addr | input | NUM_CORES*ADDR_W | Per-core byte address, core i in bits [i*ADDR_W +: ADDR_W] |
| tick | input | NUM_CORES | Per-core instruction tick |
| stall | output | NUM_CORES | Core is waiting for a line owned by another core |
| granted | output | NUM_CORES | One-cycle pulse: core has just become owner |
| sc_valid | output | NUM_CORES | One-cycle store-conditional reply strobe |
| sc_ok | output | NUM_CORES | Store-conditional passed (valid with sc_valid) |

## Verification
On every cycle, the assertions check the following:
- No line has two owners.
- Every stalled core has a live owner on its line.
- An owner's count stays between 1 and 64, starts full on grant, and steps down only on ticks.
- A final tick ends ownership.
- Each store-conditional draws exactly one reply one cycle later, and a non-owner never gets a pass.

Only the bench scenarios can show the rest:
- Which core a release hands the line to.
- The exact 63/64-tick boundary between passing and lapsing.
- That stalls persist over tickless cycles.
- That reset frees a contended line.

// File: rtl/resv_pkg.sv
package resv_pkg;

    typedef enum logic [1:0] {
        CS_IDLE = 2'd0,
        CS_WAIT = 2'd1,
        CS_OWN  = 2'd2
    } core_state_e;

    typedef enum logic {
        OP_RESERVE = 1'b0,
        OP_STCOND  = 1'b1
    } req_op_e;

endpackage

// File: rtl/resv_match.sv
// Same-cycle contention resolver: a candidate loses when its line is kept
// by a current owner or when a lower-indexed candidate targets that line.
module resv_match #(
    parameter int NUM_CORES = 4,
    parameter int LINE_W    = 26
) (
    input  logic [NUM_CORES-1:0]             cand,
    input  logic [NUM_CORES-1:0][LINE_W-1:0] cand_line,
    input  logic [NUM_CORES-1:0]             keep_own,
    input  logic [NUM_CORES-1:0][LINE_W-1:0] own_line,
    output logic [NUM_CORES-1:0]             win,
    output logic [NUM_CORES-1:0]             lose
);

    for (genvar gi = 0; gi < NUM_CORES; gi++) begin : g_req
        logic blocked;

        always_comb begin
            blocked = 1'b0;
            for (int j = 0; j < NUM_CORES; j++) begin
                if (keep_own[j] && (own_line[j] == cand_line[gi])) begin
                    blocked = 1'b1;
                end
                if ((j < gi) && cand[j] && (cand_line[j] == cand_line[gi])) begin
                    blocked = 1'b1;
                end
            end
        end

        assign win[gi]  = cand[gi] && !blocked;
        assign lose[gi] = cand[gi] && blocked;
    end

endmodule

// File: rtl/resv_core.sv
// Per-core reservation state machine with its instruction-tick countdown.
module resv_core
    import resv_pkg::*;
#(
    parameter int LINE_W     = 26,
    parameter int CNT_W      = 7,
    parameter int RESV_TICKS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_op,
    input  logic [LINE_W-1:0] req_line,
    input  logic              tick,
    input  logic              win,
    input  logic              lose,
    output logic              cand,
    output logic [LINE_W-1:0] cand_line,
    output logic              keep_own,
    output logic [1:0]        state_o,
    output logic [LINE_W-1:0] line_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              stall,
    output logic              granted,
    output logic              sc_valid,
    output logic              sc_ok
);

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(RESV_TICKS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

    core_state_e       state_q, state_d;
    logic [LINE_W-1:0] line_q, line_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              granted_q, sc_valid_q, sc_ok_q;

    req_op_e op;
    logic    is_reserve, is_stcond, last_tick;

    assign op         = req_op_e'(req_op);
    assign is_reserve = req_valid && (op == OP_RESERVE);
    assign is_stcond  = req_valid && (op == OP_STCOND);
    assign last_tick  = tick && (cnt_q == CNT_LAST);

    // Requests into the resolver
    assign cand      = (state_q == CS_WAIT) || is_reserve;
    assign cand_line = (state_q == CS_WAIT) ? line_q : req_line;
    assign keep_own  = (state_q == CS_OWN) && !req_valid && !last_tick;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        line_d  = line_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            CS_IDLE: begin
                if (win) begin
                    state_d = CS_OWN;
                    line_d  = cand_line;
                    cnt_d   = CNT_FULL;
                end else if (lose) begin
                    state_d = CS_WAIT;
                    line_d  = cand_line;
                end
            end
            CS_WAIT: begin
                if (win) begin
                    state_d = CS_OWN;
                    cnt_d   = CNT_FULL;
                end
            end
            CS_OWN: begin
                if (win) begin
                    line_d = cand_line;
                    cnt_d  = CNT_FULL;
                end else if (lose) begin
                    state_d = CS_WAIT;
                    line_d  = cand_line;
                    cnt_d   = '0;
                end else if (keep_own) begin
                    if (tick) begin
                        cnt_d = cnt_q - CNT_LAST;
                    end
                end else begin
                    state_d = CS_IDLE;
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = CS_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CS_IDLE;
            line_q  <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            line_q  <= line_d;
            cnt_q   <= cnt_d;
        end
    end

    // Registered reply outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            granted_q  <= 1'b0;
            sc_valid_q <= 1'b0;
            sc_ok_q    <= 1'b0;
        end else begin
            granted_q  <= win;
            sc_valid_q <= is_stcond;
            sc_ok_q    <= is_stcond && (state_q == CS_OWN) &&
                          (line_q == req_line) && (cnt_q != '0);
        end
    end

    // Output process
    always_comb begin
        stall    = (state_q == CS_WAIT);
        granted  = granted_q;
        sc_valid = sc_valid_q;
        sc_ok    = sc_ok_q;
        state_o  = state_q;
        line_o   = line_q;
        cnt_o    = cnt_q;
    end

endmodule

// File: rtl/resv_arbiter.sv
module resv_arbiter
    import resv_pkg::*;
#(
    parameter int NUM_CORES  = 4,
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int RESV_TICKS = 64
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_CORES-1:0]        req_valid,
    input  logic [NUM_CORES-1:0]        req_op,
    input  logic [NUM_CORES*ADDR_W-1:0] req_addr,
    input  logic [NUM_CORES-1:0]        tick,
    output logic [NUM_CORES-1:0]        stall,
    output logic [NUM_CORES-1:0]        granted,
    output logic [NUM_CORES-1:0]        sc_valid,
    output logic [NUM_CORES-1:0]        sc_ok
);

    localparam int LINE_OFS = $clog2(LINE_BYTES);
    localparam int LINE_W   = ADDR_W - LINE_OFS;
    localparam int CNT_W    = $clog2(RESV_TICKS + 1);

    logic [NUM_CORES-1:0]             cand, keep_own, win, lose;
    logic [NUM_CORES-1:0][LINE_W-1:0] cand_line, core_line;
    logic [NUM_CORES-1:0][1:0]        core_state;
    logic [NUM_CORES-1:0][CNT_W-1:0]  core_cnt;

    for (genvar gc = 0; gc < NUM_CORES; gc++) begin : g_core
        logic [LINE_W-1:0] req_line;

        assign req_line = req_addr[gc*ADDR_W + LINE_OFS +: LINE_W];

        resv_core #(
            .LINE_W    (LINE_W),
            .CNT_W     (CNT_W),
            .RESV_TICKS(RESV_TICKS)
        ) u_core (
            .clk      (clk),
            .rst_n    (rst_n),
            .req_valid(req_valid[gc]),
            .req_op   (req_op[gc]),
            .req_line (req_line),
            .tick     (tick[gc]),
            .win      (win[gc]),
            .lose     (lose[gc]),
            .cand     (cand[gc]),
            .cand_line(cand_line[gc]),
            .keep_own (keep_own[gc]),
            .state_o  (core_state[gc]),
            .line_o   (core_line[gc]),
            .cnt_o    (core_cnt[gc]),
            .stall    (stall[gc]),
            .granted  (granted[gc]),
            .sc_valid (sc_valid[gc]),
            .sc_ok    (sc_ok[gc])
        );
    end

    resv_match #(
        .NUM_CORES(NUM_CORES),
        .LINE_W   (LINE_W)
    ) u_match (
        .cand     (cand),
        .cand_line(cand_line),
        .keep_own (keep_own),
        .own_line (core_line),
        .win      (win),
        .lose     (lose)
    );

endmodule

// File: rtl/resv_arbiter_chk.sv
module resv_arbiter_chk
    import resv_pkg::*;
#(
    parameter int NUM_CORES  = 4,
    parameter int LINE_W     = 26,
    parameter int CNT_W      = 7,
    parameter int RESV_TICKS = 64
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic [NUM_CORES-1:0]             req_valid,
    input logic [NUM_CORES-1:0]             req_op,
    input logic [NUM_CORES-1:0]             tick,
    input logic [NUM_CORES-1:0]             stall,
    input logic [NUM_CORES-1:0]             granted,
    input logic [NUM_CORES-1:0]             sc_valid,
    input logic [NUM_CORES-1:0]             sc_ok,
    input logic [NUM_CORES-1:0][1:0]        state,
    input logic [NUM_CORES-1:0][LINE_W-1:0] line,
    input logic [NUM_CORES-1:0][CNT_W-1:0]  cnt
);

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(RESV_TICKS);
    localparam logic [1:0]       ST_OWN   = 2'(CS_OWN);

    logic [NUM_CORES-1:0] has_owner;
    logic                 dup_owner;

    always_comb begin
        dup_owner = 1'b0;
        for (int i = 0; i < NUM_CORES; i++) begin
            has_owner[i] = 1'b0;
            for (int j = 0; j < NUM_CORES; j++) begin
                if ((j != i) && (state[j] == ST_OWN) && (line[j] == line[i])) begin
                    has_owner[i] = 1'b1;
                    if ((j > i) && (state[i] == ST_OWN)) begin
                        dup_owner = 1'b1;
                    end
                end
            end
        end
    end

    assert_single_owner_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !dup_owner);

    for (genvar gi = 0; gi < NUM_CORES; gi++) begin : g_chk
        assert_stall_has_owner_R2: assert property (@(posedge clk) disable iff (!rst_n)
            stall[gi] |-> has_owner[gi]);

        assert_grant_full_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
            granted[gi] |-> (state[gi] == ST_OWN) && (cnt[gi] == CNT_FULL));

        assert_hold_without_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (state[gi] == ST_OWN) && !tick[gi] && !req_valid[gi]
            |=> (state[gi] == ST_OWN) && (cnt[gi] == $past(cnt[gi])));

        assert_step_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (state[gi] == ST_OWN) && tick[gi] && !req_valid[gi] && (cnt[gi] > 1)
            |=> (cnt[gi] == $past(cnt[gi]) - 1'b1));

        assert_owner_count_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (state[gi] == ST_OWN) |-> (cnt[gi] != '0) && (cnt[gi] <= CNT_FULL));

        assert_last_tick_lapses_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (state[gi] == ST_OWN) && tick[gi] && !req_valid[gi] && (cnt[gi] == 1)
            |=> (state[gi] != ST_OWN));

        assert_non_owner_fails_R8: assert property (@(posedge clk) disable iff (!rst_n)
            req_valid[gi] && req_op[gi] && (state[gi] != ST_OWN) |=> !sc_ok[gi]);

        assert_reply_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
            req_valid[gi] && req_op[gi] |=> sc_valid[gi]);

        assert_no_spurious_reply_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !(req_valid[gi] && req_op[gi]) |=> !sc_valid[gi]);

        assert_ok_qualified_R9: assert property (@(posedge clk) disable iff (!rst_n)
            sc_ok[gi] |-> sc_valid[gi]);
    end

endmodule

bind resv_arbiter resv_arbiter_chk #(
    .NUM_CORES (NUM_CORES),
    .LINE_W    (LINE_W),
    .CNT_W     (CNT_W),
    .RESV_TICKS(RESV_TICKS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_op   (req_op),
    .tick     (tick),
    .stall    (stall),
    .granted  (granted),
    .sc_valid (sc_valid),
    .sc_ok    (sc_ok),
    .state    (core_state),
    .line     (core_line),
    .cnt      (core_cnt)
);

// File: tb/resv_arbiter_tb.sv
module resv_arbiter_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NC = 4;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NC-1:0] req_valid = '0;
    logic [NC-1:0] req_op = '0;
    logic [NC-1:0] tick = '0;
    logic [NC*AW-1:0] req_addr = '0;
    logic [NC-1:0] stall, granted, sc_valid, sc_ok;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    bit exp_q[NC][$];

    always #(CLK_PERIOD/2) clk = ~clk;

    resv_arbiter u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .tick(tick), .stall(stall), .granted(granted),
        .sc_valid(sc_valid), .sc_ok(sc_ok)
    );

    task automatic check_eq(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic lr(int c, int addr);
        req_valid[c] = 1'b1;
        req_op[c] = 1'b0;
        req_addr[c*AW +: AW] = AW'(addr);
        step();
        req_valid[c] = 1'b0;
    endtask

    // Driver: queue the expected reply, then issue the store-conditional.
    task automatic sc(int c, int addr, bit exp);
        exp_q[c].push_back(exp);
        req_valid[c] = 1'b1;
        req_op[c] = 1'b1;
        req_addr[c*AW +: AW] = AW'(addr);
        step();
        req_valid[c] = 1'b0;
        check_eq("R9 sc_valid after request", int'(sc_valid[c]), 1);
    endtask

    task automatic ticks(int c, int n);
        tick[c] = 1'b1;
        repeat (n) step();
        tick[c] = 1'b0;
    endtask

    // Monitor: pop and compare every reply the design produces.
    always @(negedge clk) begin
        if (rst_n) begin
            for (int c = 0; c < NC; c++) begin
                if (sc_valid[c]) begin
                    if (exp_q[c].size() == 0) begin
                        check_eq("R9 unexpected sc reply", 1, 0);
                    end else begin
                        check_eq($sformatf("R4/R5/R8 sc_ok core %0d", c),
                                 int'(sc_ok[c]), int'(exp_q[c].pop_front()));
                    end
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R10: idle after reset
        check_eq("R10 stall reset", int'(stall), 0);
        check_eq("R10 granted reset", int'(granted), 0);
        check_eq("R10 sc_valid reset", int'(sc_valid), 0);

        // R1: free line grant
        lr(0, 'h40);
        check_eq("R1 granted", int'(granted[0]), 1);
        check_eq("R1 no stall", int'(stall[0]), 0);
        step();
        check_eq("R1 granted is a pulse", int'(granted[0]), 0);

        // R2: same line, different byte -> stall; owner unaffected
        lr(1, 'h48);
        check_eq("R2 stall", int'(stall[1]), 1);
        check_eq("R2 no grant", int'(granted[1]), 0);
        sc(0, 'h40, 1'b1);
        check_eq("R6 waiter granted", int'(granted[1]), 1);
        check_eq("R6 waiter unstalled", int'(stall[1]), 0);
        step();
        check_eq("R9 sc_valid one cycle", int'(sc_valid[0]), 0);

        // R4: 63 ticks then SC with a same-cycle tick passes
        ticks(1, 63);
        tick[1] = 1'b1;
        sc(1, 'h40, 1'b1);
        tick[1] = 1'b0;

        // R3/R5: lapse after 64 ticks hands line to waiter
        lr(2, 'h80);
        check_eq("R1 granted core2", int'(granted[2]), 1);
        lr(3, 'h9C);
        check_eq("R2 stall core3", int'(stall[3]), 1);
        ticks(2, 63);
        repeat (3) step();
        check_eq("R3 stall held over tickless cycles", int'(stall[3]), 1);
        ticks(2, 1);
        check_eq("R5 lapse grants waiter", int'(granted[3]), 1);
        check_eq("R5 waiter unstalled", int'(stall[3]), 0);
        sc(2, 'h80, 1'b0);
        ticks(3, 10);
        sc(3, 'h80, 1'b1);

        // R7: three same-cycle requesters, ascending order
        for (int c = 1; c < NC; c++) begin
            req_valid[c] = 1'b1;
            req_op[c] = 1'b0;
            req_addr[c*AW +: AW] = AW'('hC0);
        end
        step();
        req_valid = '0;
        check_eq("R7 core1 first", int'(granted[1]), 1);
        check_eq("R7 core2 stalled", int'(stall[2]), 1);
        check_eq("R7 core3 stalled", int'(stall[3]), 1);
        sc(1, 'hC0, 1'b1);
        check_eq("R7 core2 next", int'(granted[2]), 1);
        check_eq("R7 core3 still stalled", int'(stall[3]), 1);
        sc(2, 'hC0, 1'b1);
        check_eq("R7 core3 last", int'(granted[3]), 1);
        sc(3, 'hC0, 1'b1);

        // R8/R11: non-owner SCs, independent lines
        sc(0, 'h100, 1'b0);
        lr(1, 'h100);
        lr(2, 'h100);
        check_eq("R2 core2 stalled", int'(stall[2]), 1);
        sc(2, 'h100, 1'b0);
        check_eq("R8 waiter stays stalled", int'(stall[2]), 1);
        lr(0, 'h140);
        check_eq("R11 other line granted", int'(granted[0]), 1);
        check_eq("R11 other line not stalled", int'(stall[0]), 0);
        sc(1, 'h140, 1'b0);
        check_eq("R6 release by failed SC grants waiter", int'(granted[2]), 1);
        sc(0, 'h140, 1'b1);
        sc(2, 'h100, 1'b1);

        // R10: reset frees a contended line
        lr(0, 'h180);
        lr(1, 'h180);
        check_eq("R2 core1 stalled before reset", int'(stall[1]), 1);
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        step();
        check_eq("R10 stall cleared", int'(stall), 0);
        lr(1, 'h180);
        check_eq("R10 line free after reset", int'(granted[1]), 1);
        sc(1, 'h180, 1'b1);

        step();
        step();
        for (int c = 0; c < NC; c++) begin
            check_eq("R9 all replies seen", exp_q[c].size(), 0);
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule